// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block is an I2C bus master that runs a whole programmed transaction without further intervention. Software loads a target address, one or two byte counts, a message count and a few control bits, places outgoing bytes in an 8-entry byte FIFO, and writes a launch bit. The sequencer then produces START, address, data, acknowledge, repeated START and STOP phases on open-drain SCL and SDA lines. Received bytes are placed in the same FIFO.

Three kinds of transaction are supported: a series of write messages, a series of read messages, and a combined write-then-read. The combined form turns the bus around with a repeated START and a direction change. Outcomes are reported as sticky interrupt status bits, cleared by writing ones, and gated by a mask onto a single interrupt line. A missing acknowledge from the target and loss of arbitration to another master are both detected. The SCL half period in clock cycles is a static input.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset, the interrupt status (word 3) reads 0, the FIFO status (word 9) reads 2 (empty, not full), the interrupt output is low and neither bus line is pulled low. Status bit 2 never sets.
- R2: The FIFO holds 8 bytes. FIFO status bit 0 is full and bit 1 is empty. A write to the data word (0) while the FIFO is full is dropped. Writing 1 to bit 0 of word 8 empties the FIFO. A read of word 0 returns the oldest byte and removes it.
- R3: In write mode (control bit 4 clear, address bit 0 clear), each of the N messages (word 6) sends START, then the address byte (word 1 bits [7:1] followed by 0), then transfer-length bits [7:0] bytes taken from the FIFO in order.
- R4: In read mode (address bit 0 set), each message receives transfer-length bits [7:0] bytes into the FIFO. The master acknowledges every byte except the last, which it does not acknowledge.
- R5: With control bit 4 set, the count in word 6 is ignored and the transaction has exactly two messages. The first writes transfer-length bits [7:0] bytes with direction bit 0. The second reads transfer-length bits [15:8] bytes with direction bit 1. Address bit 0 is ignored.
- R6: Between messages, a repeated START is used when control bit 1 is set, and status bit 4 is set at each such turn. When control bit 1 is clear, the master sends STOP followed by a new START.
- R7: Status bit 0 sets once the final STOP has been sent, and the bus is then released.
- R8: With control bit 5 set, a missing acknowledge to an address byte or a written byte sets status bit 1 and sends STOP. The remaining bytes are abandoned and stay in the FIFO. Status bit 0 follows in a later cycle. With control bit 5 clear, a missing acknowledge has no effect.
- R9: If SDA reads low while the master is sending a 1 in an address or data bit, status bit 3 sets. The master then releases both lines and stops without setting bit 0.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. The interrupt output is the OR of the status bits ANDed with the mask (word 2, same bit layout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register word index |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the FIFO on word 0) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| half_period_i | input | HALF_W | SCL half period in clock cycles |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_lo_o | output | 1 | Pull SCL low when 1 |
| sda_lo_o | output | 1 | Pull SDA low when 1 |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest states to reach from the ports are a missing acknowledge partway through a write message and a lost arbitration. Both depend on what the far side of the bus does within a single bit slot. The bench attaches a behavioural target on the wired-AND bus. The target's ACK can be withheld at a chosen byte index, or it can ignore a non-matching address. A separate bench force pulls SDA low during the address phase to defeat a transmitted 1. Status is polled every two cycles, which shows that the error flag appears before the completion flag.

// File: rtl/i2c_txn_pkg.sv
`timescale 1ns/1ps
package i2c_txn_pkg;
  localparam logic [3:0] RA_DATA  = 4'd0;
  localparam logic [3:0] RA_TADDR = 4'd1;
  localparam logic [3:0] RA_IMASK = 4'd2;
  localparam logic [3:0] RA_ISTAT = 4'd3;
  localparam logic [3:0] RA_CTRL  = 4'd4;
  localparam logic [3:0] RA_XLEN  = 4'd5;
  localparam logic [3:0] RA_NMSG  = 4'd6;
  localparam logic [3:0] RA_GO    = 4'd7;
  localparam logic [3:0] RA_FCLR  = 4'd8;
  localparam logic [3:0] RA_FSTAT = 4'd9;

  localparam int STAT_W = 5;
  localparam int CT_RS = 1, CT_DIR = 4, CT_ACKDET = 5;

  typedef enum logic [3:0] {
    E_IDLE, E_STA_A, E_STA_B, E_BIT_L, E_BIT_H, E_RS, E_STO_A, E_STO_B, E_STO_C
  } eng_state_e;

  typedef struct packed {
    logic [7:0] taddr;
    logic       rs_en;
    logic       dir_chg;
    logic       ack_det;
    logic [7:0] len0;
    logic [7:0] len1;
    logic [7:0] nmsg;
  } txn_cfg_t;
endpackage

// File: rtl/i2c_txn_fifo.sv
`timescale 1ns/1ps
module i2c_txn_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
  assert_push_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_push && !do_pop && !clr_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/i2c_txn_tick.sv
`timescale 1ns/1ps
module i2c_txn_tick #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] half_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, half_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_txn_engine.sv
`timescale 1ns/1ps
module i2c_txn_engine
  import i2c_txn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       go_i,
  input  txn_cfg_t   cfg_i,
  input  logic [7:0] fifo_rdata_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic       scl_lo_o,
  output logic       sda_lo_o,
  output logic       fifo_pop_o,
  output logic       fifo_push_o,
  output logic [7:0] fifo_wdata_o,
  output logic       ev_done_o,
  output logic       ev_ackerr_o,
  output logic       ev_arb_o,
  output logic       ev_rs_o
);
  eng_state_e st_q;
  logic [7:0] sh_q, left_q, msg_q;
  logic [3:0] bit_q;
  logic       addr_ph_q, rd_q, final_q;
  logic       tx_ph, last_msg, next_rd, bit_lo;
  logic [7:0] next_len;

  assign busy_o   = (st_q != E_IDLE);
  assign tx_ph    = addr_ph_q || !rd_q;
  assign last_msg = ({1'b0, msg_q} + 9'd1) >= (cfg_i.dir_chg ? 9'd2 : {1'b0, cfg_i.nmsg});
  assign next_rd  = cfg_i.dir_chg ? (msg_q != 8'd0) : cfg_i.taddr[0];
  assign next_len = (cfg_i.dir_chg && msg_q != 8'd0) ? cfg_i.len1 : cfg_i.len0;
  // data slot: drive only when sending; ack slot: ACK reads while bytes remain
  assign bit_lo   = (bit_q < 4'd8) ? (tx_ph && !sh_q[7]) : (!tx_ph && left_q != 8'd0);

  always_comb begin
    scl_lo_o = 1'b0;
    sda_lo_o = 1'b0;
    unique case (st_q)
      E_STA_B: sda_lo_o = 1'b1;
      E_BIT_L: begin scl_lo_o = 1'b1; sda_lo_o = bit_lo; end
      E_BIT_H: sda_lo_o = bit_lo;
      E_RS:    scl_lo_o = 1'b1;
      E_STO_A: begin scl_lo_o = 1'b1; sda_lo_o = 1'b1; end
      E_STO_B: sda_lo_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= E_IDLE; sh_q <= '0; left_q <= '0; msg_q <= '0; bit_q <= '0;
      addr_ph_q <= 1'b0; rd_q <= 1'b0; final_q <= 1'b0;
      fifo_pop_o <= 1'b0; fifo_push_o <= 1'b0; fifo_wdata_o <= '0;
      ev_done_o <= 1'b0; ev_ackerr_o <= 1'b0; ev_arb_o <= 1'b0; ev_rs_o <= 1'b0;
    end else begin
      fifo_pop_o <= 1'b0; fifo_push_o <= 1'b0;
      ev_done_o <= 1'b0; ev_ackerr_o <= 1'b0; ev_arb_o <= 1'b0; ev_rs_o <= 1'b0;
      if (st_q == E_IDLE) begin
        if (go_i) begin st_q <= E_STA_A; msg_q <= '0; end
      end else if (tick_i) begin
        unique case (st_q)
          E_STA_A: st_q <= E_STA_B;
          E_STA_B: begin
            sh_q <= {cfg_i.taddr[7:1], next_rd};
            rd_q <= next_rd; left_q <= next_len;
            addr_ph_q <= 1'b1; bit_q <= '0; st_q <= E_BIT_L;
          end
          E_BIT_L: st_q <= E_BIT_H;
          E_BIT_H: begin
            if (bit_q < 4'd8) begin
              if (tx_ph && sh_q[7] && !sda_i) begin
                ev_arb_o <= 1'b1; st_q <= E_IDLE;
              end else begin
                sh_q <= {sh_q[6:0], sda_i}; bit_q <= bit_q + 1'b1; st_q <= E_BIT_L;
              end
            end else if (tx_ph && sda_i && cfg_i.ack_det) begin
              ev_ackerr_o <= 1'b1; final_q <= 1'b1; st_q <= E_STO_A;
            end else begin
              if (!tx_ph) begin fifo_push_o <= 1'b1; fifo_wdata_o <= sh_q; end
              addr_ph_q <= 1'b0;
              if (left_q != 8'd0) begin
                left_q <= left_q - 1'b1; bit_q <= '0; st_q <= E_BIT_L;
                if (!rd_q) begin sh_q <= fifo_rdata_i; fifo_pop_o <= 1'b1; end
                else sh_q <= 8'hFF;
              end else if (last_msg) begin
                final_q <= 1'b1; st_q <= E_STO_A;
              end else begin
                msg_q <= msg_q + 1'b1;
                if (cfg_i.rs_en) begin ev_rs_o <= 1'b1; st_q <= E_RS; end
                else begin final_q <= 1'b0; st_q <= E_STO_A; end
              end
            end
          end
          E_RS:    st_q <= E_STA_A;
          E_STO_A: st_q <= E_STO_B;
          E_STO_B: st_q <= E_STO_C;
          E_STO_C: begin
            if (final_q) begin ev_done_o <= 1'b1; st_q <= E_IDLE; end
            else st_q <= E_STA_A;
          end
          default: st_q <= E_IDLE;
        endcase
      end
    end
  end

  assert_err_not_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_ackerr_o |-> !ev_done_o);
  assert_arb_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_arb_o |-> (!busy_o && !scl_lo_o && !sda_lo_o));
  assert_done_bus_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_done_o |-> (!scl_lo_o && !sda_lo_o));
endmodule

// File: rtl/i2c_txn_seq.sv
`timescale 1ns/1ps
module i2c_txn_seq
  import i2c_txn_pkg::*;
#(
  parameter int HALF_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic [HALF_W-1:0] half_period_i,
  input  logic              sda_i,
  output logic              scl_lo_o,
  output logic              sda_lo_o,
  output logic              irq_o
);
  logic [7:0]        taddr_q, nmsg_q;
  logic [15:0]       xlen_q;
  logic [STAT_W-1:0] mask_q, stat_q, ev_vec, clr_vec;
  logic              rs_q, dir_q, ackdet_q;
  txn_cfg_t          cfg;
  logic busy, tick, go;
  logic e_pop, e_push, e_done, e_ackerr, e_arb, e_rs;
  logic [7:0] e_wdata, f_rdata;
  logic f_full, f_empty, h_push, h_pop, f_clr;

  assign h_push = reg_we_i && reg_addr_i == RA_DATA;
  assign h_pop  = reg_re_i && reg_addr_i == RA_DATA;
  assign f_clr  = reg_we_i && reg_addr_i == RA_FCLR && reg_wdata_i[0];
  assign go     = reg_we_i && reg_addr_i == RA_GO && reg_wdata_i[0];

  always_comb begin
    cfg.taddr = taddr_q; cfg.rs_en = rs_q; cfg.dir_chg = dir_q; cfg.ack_det = ackdet_q;
    cfg.len0 = xlen_q[7:0]; cfg.len1 = xlen_q[15:8]; cfg.nmsg = nmsg_q;
  end

  assign ev_vec  = {e_rs, e_arb, 1'b0, e_ackerr, e_done};
  assign clr_vec = (reg_we_i && reg_addr_i == RA_ISTAT) ? reg_wdata_i[STAT_W-1:0] : '0;
  assign irq_o   = |(stat_q & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taddr_q <= '0; nmsg_q <= 8'd1; xlen_q <= '0; mask_q <= '0; stat_q <= '0;
      rs_q <= 1'b0; dir_q <= 1'b0; ackdet_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | ev_vec;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          RA_TADDR: taddr_q <= reg_wdata_i[7:0];
          RA_IMASK: mask_q  <= reg_wdata_i[STAT_W-1:0];
          RA_CTRL: begin
            rs_q <= reg_wdata_i[CT_RS]; dir_q <= reg_wdata_i[CT_DIR];
            ackdet_q <= reg_wdata_i[CT_ACKDET];
          end
          RA_XLEN: xlen_q <= reg_wdata_i;
          RA_NMSG: nmsg_q <= reg_wdata_i[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_DATA:  reg_rdata_o = {8'd0, f_rdata};
      RA_TADDR: reg_rdata_o = {8'd0, taddr_q};
      RA_IMASK: reg_rdata_o = 16'(mask_q);
      RA_ISTAT: reg_rdata_o = 16'(stat_q);
      RA_CTRL:  reg_rdata_o = {10'd0, ackdet_q, dir_q, 2'b00, rs_q, 1'b0};
      RA_XLEN:  reg_rdata_o = xlen_q;
      RA_NMSG:  reg_rdata_o = {8'd0, nmsg_q};
      RA_FSTAT: reg_rdata_o = {14'd0, f_empty, f_full};
      default:  reg_rdata_o = '0;
    endcase
  end

  i2c_txn_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(f_clr),
    .push_i(e_push || h_push), .wdata_i(e_push ? e_wdata : reg_wdata_i[7:0]),
    .pop_i(e_pop || h_pop), .rdata_o(f_rdata), .full_o(f_full), .empty_o(f_empty)
  );

  i2c_txn_tick #(.W(HALF_W)) u_tick (
    .clk_i, .rst_ni, .en_i(busy), .half_i(half_period_i), .tick_o(tick)
  );

  i2c_txn_engine u_eng (
    .clk_i, .rst_ni, .tick_i(tick), .go_i(go), .cfg_i(cfg), .fifo_rdata_i(f_rdata),
    .sda_i, .busy_o(busy), .scl_lo_o, .sda_lo_o, .fifo_pop_o(e_pop),
    .fifo_push_o(e_push), .fifo_wdata_o(e_wdata), .ev_done_o(e_done),
    .ev_ackerr_o(e_ackerr), .ev_arb_o(e_arb), .ev_rs_o(e_rs)
  );

  assert_w1c_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RA_ISTAT && reg_wdata_i[0] && !e_done) |=> !stat_q[0]);
  assert_hs_bit_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q[2]);
endmodule

// File: tb/i2c_txn_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_txn_seq_tb_top;
  import i2c_txn_pkg::*;
  localparam logic [6:0] TGT = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wd = '0, rdata;
  logic        scl_lo, sda_lo, irq;
  logic        tgt_lo = 1'b0, arb_force = 1'b0, tgt_clr = 1'b0;
  wire         scl_bus = !scl_lo;
  wire         sda_bus = !(sda_lo || tgt_lo || arb_force);

  i2c_txn_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .half_period_i(8'd4), .sda_i(sda_bus),
    .scl_lo_o(scl_lo), .sda_lo_o(sda_lo), .irq_o(irq)
  );

  // behavioural target on the wired-AND bus
  logic pscl = 1'b1, psda = 1'b1, tfirst = 1'b0, mack = 1'b0;
  int   tstate = 0, tbit = 0, wcnt = 0, ridx = 0, starts = 0, stops = 0, nack_at = -1;
  logic [7:0] tsh = '0, txb = '0;
  logic [7:0] wlog [0:31];
  logic [7:0] rmem [0:31];

  always @(posedge clk) begin
    pscl <= scl_bus; psda <= sda_bus;
    if (tgt_clr) begin
      wcnt <= 0; ridx <= 0; starts <= 0; stops <= 0; tstate <= 0; tgt_lo <= 1'b0;
    end else if (scl_bus && pscl && psda && !sda_bus) begin
      starts <= starts + 1; tstate <= 1; tbit <= 0; tgt_lo <= 1'b0;
    end else if (scl_bus && pscl && !psda && sda_bus) begin
      stops <= stops + 1; tstate <= 0; tgt_lo <= 1'b0;
    end else if (tstate != 0 && scl_bus && !pscl) begin
      if (tbit < 8 && tstate != 3) tsh <= {tsh[6:0], sda_bus};
      if (tbit == 8 && tstate == 3) mack <= !sda_bus;
      tbit <= tbit + 1;
    end else if (tstate != 0 && !scl_bus && pscl) begin
      if (tbit == 8) begin
        if (tstate == 1) begin
          if (tsh[7:1] == TGT) begin tgt_lo <= 1'b1; tstate <= tsh[0] ? 3 : 2; tfirst <= 1'b1; end
          else begin tgt_lo <= 1'b0; tstate <= 0; end
        end else if (tstate == 2) begin
          wlog[wcnt] <= tsh; tgt_lo <= (wcnt != nack_at); wcnt <= wcnt + 1;
        end else tgt_lo <= 1'b0;
      end else if (tbit == 9) begin
        tbit <= 0;
        if (tstate == 3 && (tfirst || mack)) begin
          txb <= rmem[ridx]; tgt_lo <= !rmem[ridx][7]; ridx <= ridx + 1; tfirst <= 1'b0;
        end else tgt_lo <= 1'b0;
      end else if (tbit >= 1 && tbit <= 7 && tstate == 3) tgt_lo <= !txb[7-tbit];
    end
  end

  int checks = 0, fails = 0;
  logic [7:0] wdat [0:7];
  logic [15:0] st, d;
  int t_err, t_done;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] abyte(input logic [6:0] a, input logic rd);
    return {8'd0, a, rd};
  endfunction

  function automatic logic [15:0] ctl(input logic rs, input logic dir, input logic ack);
    return 16'((ack << CT_ACKDET) | (dir << CT_DIR) | (rs << CT_RS));
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk); addr = a; wd = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; re = 1'b1; #1 v = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic prep();
    wr(RA_ISTAT, 16'h1F); wr(RA_FCLR, 16'h1);
    @(negedge clk); tgt_clr = 1'b1; @(negedge clk); tgt_clr = 1'b0;
  endtask

  task automatic run(output logic [15:0] s, output int te, output int td);
    te = -1; td = -1; s = '0;
    wr(RA_GO, 16'h1);
    for (int i = 0; i < 6000; i++) begin
      rd(RA_ISTAT, s);
      if (s[1] && te < 0) te = i;
      if (s[0] && td < 0) td = i;
      if (s[0] || s[3]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic push_rand(input int n);
    for (int i = 0; i < n; i++) begin
      wdat[i] = 8'($urandom); wr(RA_DATA, {8'd0, wdat[i]});
    end
  endtask

  task automatic write_case(input int n, input int nm, input logic rs, input string req);
    prep(); push_rand(n * nm);
    wr(RA_TADDR, abyte(TGT, 1'b0)); wr(RA_CTRL, ctl(rs, 1'b0, 1'b1));
    wr(RA_XLEN, 16'(n)); wr(RA_NMSG, 16'(nm));
    run(st, t_err, t_done);
    chk({req, " write count"}, wcnt, n * nm);
    for (int i = 0; i < n * nm; i++) chk({req, " write byte"}, wlog[i], wdat[i]);
    chk({req, " status"}, st, (nm > 1 && rs) ? 16'h11 : 16'h01);
    chk({req, " starts"}, starts, nm);
    chk({req, " stops"}, stops, rs ? 1 : nm);
  endtask

  task automatic read_case(input int n, input string req);
    prep();
    for (int i = 0; i < n; i++) rmem[i] = 8'($urandom);
    wr(RA_TADDR, abyte(TGT, 1'b1)); wr(RA_CTRL, ctl(1'b0, 1'b0, 1'b1));
    wr(RA_XLEN, 16'(n)); wr(RA_NMSG, 16'd1);
    run(st, t_err, t_done);
    chk({req, " status"}, st, 16'h01);
    chk({req, " bytes sourced (last not acked)"}, ridx, n);
    for (int i = 0; i < n; i++) begin rd(RA_DATA, d); chk({req, " read byte"}, d, rmem[i]); end
    rd(RA_FSTAT, d); chk({req, " fifo drained"}, d, 16'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk); rst_n = 1'b1; repeat (2) @(negedge clk);

    // R1 reset state
    rd(RA_ISTAT, d); chk("R1 status", d, 0);
    rd(RA_FSTAT, d); chk("R1 fifo", d, 2);
    chk("R1 scl", scl_lo, 0); chk("R1 sda", sda_lo, 0); chk("R1 irq", irq, 0);
    wr(RA_IMASK, 16'h1F);

    // R2 fifo full, overflow drop, clear
    prep(); push_rand(8); wr(RA_DATA, 16'h00EE);
    rd(RA_FSTAT, d); chk("R2 full", d, 1);
    for (int i = 0; i < 8; i++) begin rd(RA_DATA, d); chk("R2 order", d, wdat[i]); end
    rd(RA_FSTAT, d); chk("R2 empty after pops", d, 2);
    push_rand(3); wr(RA_FCLR, 16'h1); rd(RA_FSTAT, d); chk("R2 clear", d, 2);

    write_case(3, 1, 1'b0, "R3 R7");
    write_case(2, 2, 1'b0, "R3 R6 stop-start");
    write_case(2, 3, 1'b1, "R6 repeated start");
    read_case(4, "R4");
    read_case(1, "R4 single");

    // R5 combined: count and address bit0 overridden
    prep(); push_rand(2);
    for (int i = 0; i < 3; i++) rmem[i] = 8'($urandom);
    wr(RA_TADDR, abyte(TGT, 1'b1)); wr(RA_CTRL, ctl(1'b1, 1'b1, 1'b1));
    wr(RA_XLEN, 16'h0302); wr(RA_NMSG, 16'd5);
    run(st, t_err, t_done);
    chk("R5 status", st, 16'h11); chk("R5 wcount", wcnt, 2);
    chk("R5 w0", wlog[0], wdat[0]); chk("R5 w1", wlog[1], wdat[1]);
    for (int i = 0; i < 3; i++) begin rd(RA_DATA, d); chk("R5 read", d, rmem[i]); end
    chk("R5 starts", starts, 2); chk("R5 stops", stops, 1);

    // R8 address nack with detection
    prep(); push_rand(3);
    wr(RA_TADDR, abyte(7'h11, 1'b0)); wr(RA_CTRL, ctl(1'b0, 1'b0, 1'b1));
    wr(RA_XLEN, 16'd3); wr(RA_NMSG, 16'd1);
    run(st, t_err, t_done);
    chk("R8 status", st, 16'h03); chk("R8 err before done", int'(t_err < t_done), 1);
    rd(RA_FSTAT, d); chk("R8 bytes abandoned", d, 0); chk("R8 stops", stops, 1);

    // R10 w1c and mask
    wr(RA_ISTAT, 16'h0); rd(RA_ISTAT, d); chk("R10 zero write keeps", d, 3);
    wr(RA_ISTAT, 16'h1); rd(RA_ISTAT, d); chk("R10 clear bit0", d, 2);
    wr(RA_IMASK, 16'h1); #1 chk("R10 masked irq", irq, 0);
    wr(RA_IMASK, 16'h2); #1 chk("R10 unmasked irq", irq, 1);
    wr(RA_IMASK, 16'h1F);

    // R8 data nack mid-message
    prep(); nack_at = 1; push_rand(4);
    wr(RA_TADDR, abyte(TGT, 1'b0)); wr(RA_CTRL, ctl(1'b0, 1'b0, 1'b1));
    wr(RA_XLEN, 16'd4); run(st, t_err, t_done);
    chk("R8 data nack status", st, 16'h03); chk("R8 data nack sent", wcnt, 2);
    rd(RA_DATA, d); chk("R8 remaining byte", d, wdat[2]);
    nack_at = -1;

    // R8 detection off: nack ignored
    prep(); push_rand(2);
    wr(RA_TADDR, abyte(7'h11, 1'b0)); wr(RA_CTRL, ctl(1'b0, 1'b0, 1'b0));
    wr(RA_XLEN, 16'd2); run(st, t_err, t_done);
    chk("R8 ignored status", st, 16'h01);
    rd(RA_FSTAT, d); chk("R8 ignored all sent", d, 2);

    // R9 arbitration loss
    prep(); arb_force = 1'b1;
    wr(RA_TADDR, abyte(TGT, 1'b0)); wr(RA_CTRL, ctl(1'b0, 1'b0, 1'b1));
    wr(RA_XLEN, 16'd1); run(st, t_err, t_done);
    chk("R9 status", st, 16'h08); chk("R9 scl released", scl_lo, 0); chk("R9 sda released", sda_lo, 0);
    arb_force = 1'b0; repeat (10) @(negedge clk);

    // random mix
    for (int k = 0; k < 6; k++) begin
      if ($urandom % 2) write_case(1 + int'($urandom % 8), 1, 1'b0, "R3 random");
      else read_case(1 + int'($urandom % 8), "R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule